// File: doc/BRIEF.md
# Quad DAC serial command receiver

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host sends a serial bit stream on a data line together with a serial clock. Each command word is 11 bits long. A falling edge on the load strobe writes the assembled word into the input register of one of the four channels. A falling edge on the update strobe then copies all four input registers to the output registers at the same time. If the update strobe is already low when the load strobe falls, the addressed channel's output changes straight away.

All four serial-side lines are asynchronous to the system clock. The block oversamples them through two-flop synchronizers and finds their edges itself. It drives four 8-bit output codes and four gain bits to the analog section. It also raises a one-cycle error pulse when a command is too short. The analog section turns each code into `Vref * code/256 * (gain ? 2 : 1)`; that conversion lies outside this block.

Top module: `qdac_rx`

## Requirements
- R1: Each falling edge of `serClk` shifts the current `serData` level into the command word, most significant bit first.
- R2: The 11-bit command word has its channel select in bits 10:9 (0 = channel 0 through 3 = channel 3), its gain bit in bit 8 (1 selects the x2 range, 0 the x1 range), and its code in bits 7:0. The code appears on `codeOut[ch]` and the gain bit on `gainOut[ch]`.
- R3: When more than 11 bits arrive before the load strobe, only the 11 most recently received bits form the command.
- R4: If fewer than 11 bits have arrived when `loadN` falls, no register changes and `shortErr` is high for exactly one system cycle.
- R5: A falling edge of `loadN` with a complete command writes that command into the selected channel's input register. The other channels are left unchanged.
- R6: If `ldacN` is low when `loadN` falls, the selected channel's output code and gain take the new command at once.
- R7: If `ldacN` is high when `loadN` falls, the outputs keep their values. A later falling edge of `ldacN` copies all four input registers to the outputs in one cycle. If that edge comes in the same cycle as a load, the copy includes the command being loaded.
- R8: The received-bit count returns to zero after every `loadN` fall, whether the command was accepted or rejected.
- R9: When a `serClk` fall and a `loadN` fall are detected in the same system cycle, the bit is shifted in first and then counts toward the command being loaded.
- R10: After reset, all input and output codes and all gain bits are zero, and `shortErr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock; data is taken on its falling edge |
| serData | input | 1 | Serial data, MSB first |
| loadN | input | 1 | Load strobe; a falling edge commits the command |
| ldacN | input | 1 | Update strobe; a falling edge copies all input registers to the outputs |
| codeOut | output | 4x8 | Output code of each channel |
| gainOut | output | 4 | Gain-range bit of each channel |
| shortErr | output | 1 | One-cycle pulse when a command is rejected as too short |

## Verification
Two pairs of events can be detected in the same system cycle. The first pair is a serial-clock fall and a load fall. The second is a load fall and an update-strobe fall. The bench provokes each by driving both lines low on the same system clock edge, so that they pass through matching synchronizers and are seen together. In the first case it sends only ten bits beforehand and expects the command to be accepted, with the eleventh bit shifted in first. In the second case it expects the new command to reach its channel's output and all other channels to take their pending input values.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef struct packed {
    logic shiftEn;    // take one serial bit this cycle
    logic bitVal;     // value of that bit
    logic commit;     // write assembled word into the selected input register
    logic commitOut;  // also write the selected output register
    logic updateAll;  // copy every input register to its output
  } qdac_strb_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int FW = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       loadN,
  input  logic       ldacN,
  output qdac_strb_t strb,
  output logic       shortErr
);
  localparam int CNTW = $clog2(FW + 1);
  // line order: {ldacN, loadN, serData, serClk}; idle levels high except data
  localparam logic [3:0] IDLE = 4'b1101;

  logic [3:0] rawIn, sync0, sync1, syncDly, fallSeen;
  logic [CNTW-1:0] bitCnt, cntAfter;
  logic clkFall, loadFall, ldacFall;

  assign rawIn = {ldacN, loadN, serData, serClk};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync0   <= IDLE;
      sync1   <= IDLE;
      syncDly <= IDLE;
    end else begin
      sync0   <= rawIn;
      sync1   <= sync0;
      syncDly <= sync1;
    end
  end

  assign fallSeen = syncDly & ~sync1;
  assign clkFall  = fallSeen[0];
  assign loadFall = fallSeen[2];
  assign ldacFall = fallSeen[3];

  // count including a bit taken in this very cycle (serial clock wins the tie)
  always_comb begin
    cntAfter = bitCnt;
    if (clkFall && (bitCnt < CNTW'(FW))) cntAfter = bitCnt + 1'b1;
  end

  always_comb begin
    strb.shiftEn   = clkFall;
    strb.bitVal    = sync1[1];
    strb.commit    = loadFall && (cntAfter == CNTW'(FW));
    strb.commitOut = strb.commit && !sync1[3];
    strb.updateAll = ldacFall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shortErr <= 1'b0;
    end else begin
      bitCnt   <= loadFall ? '0 : cntAfter;
      shortErr <= loadFall && (cntAfter != CNTW'(FW));
    end
  end
endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  qdac_strb_t               strb,
  output logic [NCH-1:0][CW-1:0]   inCode,
  output logic [NCH-1:0]           inGain,
  output logic [NCH-1:0][CW-1:0]   codeOut,
  output logic [NCH-1:0]           gainOut
);
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int FW   = SELW + 1 + CW;

  logic [FW-1:0]   shiftReg, wordNow;
  logic [SELW-1:0] wordSel;
  logic            wordGain;
  logic [CW-1:0]   wordCode;

  assign wordNow  = strb.shiftEn ? {shiftReg[FW-2:0], strb.bitVal} : shiftReg;
  assign wordSel  = wordNow[FW-1 -: SELW];
  assign wordGain = wordNow[CW];
  assign wordCode = wordNow[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= wordNow;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic          hit;
    logic [CW-1:0] codeNext;
    logic          gainNext;

    assign hit      = strb.commit && (wordSel == SELW'(ch));
    assign codeNext = hit ? wordCode : inCode[ch];
    assign gainNext = hit ? wordGain : inGain[ch];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        inCode[ch]  <= '0;
        inGain[ch]  <= 1'b0;
        codeOut[ch] <= '0;
        gainOut[ch] <= 1'b0;
      end else begin
        inCode[ch] <= codeNext;
        inGain[ch] <= gainNext;
        if (strb.updateAll || (strb.commitOut && hit)) begin
          codeOut[ch] <= codeNext;
          gainOut[ch] <= gainNext;
        end
      end
    end
  end
endmodule

// File: rtl/qdac_rx.sv
module qdac_rx
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   serClk,
  input  logic                   serData,
  input  logic                   loadN,
  input  logic                   ldacN,
  output logic [NCH-1:0][CW-1:0] codeOut,
  output logic [NCH-1:0]         gainOut,
  output logic                   shortErr
);
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int FW   = SELW + 1 + CW;

  qdac_strb_t            strb;
  logic [NCH-1:0][CW-1:0] inCode;
  logic [NCH-1:0]         inGain;

  qdac_ctrl #(.FW(FW)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .loadN(loadN), .ldacN(ldacN), .strb(strb), .shortErr(shortErr)
  );

  qdac_datapath #(.NCH(NCH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inCode(inCode), .inGain(inGain),
    .codeOut(codeOut), .gainOut(gainOut)
  );
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input qdac_strb_t             strb,
  input logic [NCH-1:0][CW-1:0] inCode,
  input logic [NCH-1:0]         inGain,
  input logic [NCH-1:0][CW-1:0] codeOut,
  input logic [NCH-1:0]         gainOut,
  input logic                   shortErr
);
  // R4: error is a single-cycle pulse
  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    shortErr |=> !shortErr);

  // R4: an accepted command never raises the error
  assert_err_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !shortErr);

  // R7: outputs hold unless a commit-to-output or bulk update occurs
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commitOut && !strb.updateAll) |=> ($stable(codeOut) && $stable(gainOut)));

  // R7: bulk update copies input registers when no load competes
  assert_bulk_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.updateAll && !strb.commit) |=> (codeOut == $past(inCode) && gainOut == $past(inGain)));

  // R5: input registers change only on an accepted command
  assert_in_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(inCode) && $stable(inGain)));
endmodule

bind qdac_rx qdac_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .inCode(inCode), .inGain(inGain),
  .codeOut(codeOut), .gainOut(gainOut), .shortErr(shortErr)
);

// File: tb/sim_qdac_rx.sv
module sim_qdac_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b1, serData = 1'b0, loadN = 1'b1, ldacN = 1'b1;
  logic [3:0][7:0] codeOut;
  logic [3:0]      gainOut;
  logic            shortErr;

  int vecs = 0, bad = 0;
  bit done = 0;

  // bench model
  logic [10:0]     mSh = '0;
  int              mCnt = 0;
  logic [3:0][7:0] mInC = '0, mOutC = '0;
  logic [3:0]      mInG = '0, mOutG = '0;
  logic            mErr = 0;

  always #10 clk = ~clk;

  qdac_rx u0 (.clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .loadN(loadN), .ldacN(ldacN), .codeOut(codeOut), .gainOut(gainOut),
    .shortErr(shortErr));

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mkCmd(int ch, bit g, logic [7:0] c);
    return {ch[1:0], g, c};
  endfunction

  // model effects
  function automatic void mBit(bit b);
    mSh = {mSh[9:0], b};
    if (mCnt < 11) mCnt++;
  endfunction

  function automatic void mLoad(bit ldacLow, bit ldacFall);
    int ch;
    mErr = (mCnt != 11);
    if (!mErr) begin
      ch = int'(mSh[10:9]);
      mInC[ch] = mSh[7:0];
      mInG[ch] = mSh[8];
      if (ldacLow) begin
        mOutC[ch] = mSh[7:0];
        mOutG[ch] = mSh[8];
      end
    end
    if (ldacFall) begin
      mOutC = mInC;
      mOutG = mInG;
    end
    mCnt = 0;
  endfunction

  task automatic sendBit(bit b);
    serData = b; waitN(4);
    serClk = 1'b0; mBit(b); waitN(4);
    serClk = 1'b1; waitN(3);
  endtask

  task automatic sendBits(logic [15:0] w, int n);
    for (int i = n - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic checkOuts(string req);
    chk({req, " code"}, 64'(codeOut), 64'(mOutC));
    chk({req, " gain"}, 64'(gainOut), 64'(mOutG));
  endtask

  task automatic setLdac(bit v);
    if (ldacN && !v) begin mOutC = mInC; mOutG = mInG; end
    ldacN = v; waitN(5);
  endtask

  // load strobe; optional last bit on the same cycle, optional ldac fall together
  task automatic doLoad(string req, bit withBit, bit b, bit ldacFallToo);
    bit ldacLow;
    serData = b; waitN(4);
    if (withBit) begin serClk = 1'b0; mBit(b); end
    if (ldacFallToo) begin
      ldacLow = 1'b1; ldacN = 1'b0;
    end else ldacLow = !ldacN;
    loadN = 1'b0;
    mLoad(ldacLow, ldacFallToo);
    waitN(3);
    chk({req, " shortErr pulse"}, 64'(shortErr), 64'(mErr));
    waitN(1);
    chk({req, " shortErr cleared"}, 64'(shortErr), 64'd0);
    checkOuts(req);
    loadN = 1'b1; serClk = 1'b1; waitN(4);
  endtask

  task automatic flushAll(string req);
    setLdac(1'b1); setLdac(1'b0); waitN(1);
    checkOuts(req);
    setLdac(1'b1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    waitN(4);
    rstN = 1'b1;
    waitN(2);
    // R10 reset state
    chk("R10 reset code", 64'(codeOut), 64'd0);
    chk("R10 reset gain", 64'(gainOut), 64'd0);
    chk("R10 reset err", 64'(shortErr), 64'd0);

    // R1 R2 R6: immediate write with ldac low
    setLdac(1'b0);
    sendBits(16'(mkCmd(2, 1, 8'hA5)), 11);
    doLoad("R1 R2 R6 immediate", 0, 0, 0);
    chk("R2 ch2 code", 64'(codeOut[2]), 64'hA5);
    chk("R2 ch2 gain x2", 64'(gainOut[2]), 64'd1);

    // R7 held then bulk update; R5 other channels untouched
    setLdac(1'b1);
    sendBits(16'(mkCmd(0, 0, 8'h3C)), 11);
    doLoad("R7 held", 0, 0, 0);
    chk("R7 ch0 not yet", 64'(codeOut[0]), 64'h00);
    sendBits(16'(mkCmd(3, 1, 8'hFF)), 11);
    doLoad("R5 second", 0, 0, 0);
    setLdac(1'b0); waitN(1);
    checkOuts("R7 bulk");
    chk("R5 ch3 code", 64'(codeOut[3]), 64'hFF);
    chk("R5 ch2 kept", 64'(codeOut[2]), 64'hA5);
    setLdac(1'b1);

    // R3: 14 bits, only last 11 used
    sendBits({3'b101, 2'd1, 1'b0, 8'h77}, 14);
    doLoad("R3 overlong", 0, 0, 0);
    flushAll("R3 flushed");
    chk("R3 ch1", 64'(codeOut[1]), 64'h77);

    // R4 short command
    sendBits(16'h5A, 7);
    doLoad("R4 short", 0, 0, 0);
    flushAll("R4 nochange");

    // R8: valid load then immediately another load
    sendBits(16'(mkCmd(1, 1, 8'h12)), 11);
    doLoad("R8 valid", 0, 0, 0);
    doLoad("R8 zero-bit load rejected", 0, 0, 0);
    flushAll("R8 flushed");

    // R9 serial clock fall and load fall together
    sendBits(16'(mkCmd(0, 1, 8'h81)) >> 1, 10);
    doLoad("R9 same-cycle bit", 1, 1'b1, 0);
    flushAll("R9 flushed");
    chk("R9 ch0 code", 64'(codeOut[0]), 64'h81);

    // R7 load and update fall together
    sendBits(16'(mkCmd(3, 0, 8'h42)), 11);
    doLoad("R7 load+update", 0, 0, 1);
    chk("R7 ch3 new", 64'(codeOut[3]), 64'h42);
    setLdac(1'b1);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int n = 8 + int'($urandom_range(6));
      logic [15:0] w = 16'($urandom);
      if ($urandom_range(3) == 0) setLdac(!ldacN);
      sendBits(w, n);
      doLoad("R5 random", 0, 0, 0);
      if ($urandom_range(4) == 0) flushAll("R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule